// File: doc/BRIEF.md
# Output Channel Selector with Flag Return

This block sits between a single-input packet router's controller and its bank of output queues. When the controller signals that a packet header is on the input bus, the block captures the destination code from the low bits of that byte. It keeps that code until the next header arrives. The stored code picks one output queue. That queue's full and empty flags are returned to the controller as one pair, and the controller's single write strobe is sent only to that queue.

A destination code with no queue behind it makes the controller see a queue that is full and not empty. The controller then never loads the packet, and no queue receives a write. Each output port also presents a data-available indication, which is the inverse of its queue's empty flag. This indication does not depend on the stored code.

Flag selection and write steering are pure logic on the stored code, so a flag change reaches the controller in the same cycle. The only state is the stored destination code.

Top module: `chan_steer`

## Requirements
- R1: On a rising clock edge with `addr_capture` high, the stored destination code takes the value of `dest_in`. While `addr_capture` is low, the stored code keeps its value even if `dest_in` changes.
- R2: A stored code of 0, 1 or 2 makes `sel_full` equal `full_in[code]` and `sel_empty` equal `empty_in[code]`.
- R3: A stored code of 3 makes `sel_full` equal 1 and `sel_empty` equal 0, whatever the queue flags are.
- R4: `port_valid[n]` equals the inverse of `empty_in[n]` for each port n, whatever the stored code is.
- R5: With `wr_req` high and a stored code of 0 to 2, `wr_en` has exactly one bit set, and that bit is at the position given by the code.
- R6: `wr_en` is all zeros when `wr_req` is low, and also when the stored code is 3.
- R7: A rising edge with `rst_n` low clears the stored code to 0, and `addr_capture` is ignored on that edge. While `rst_n` is low, `wr_en` is all zeros.
- R8: A change on `full_in`, `empty_in` or `wr_req` appears on `sel_full`, `sel_empty` and `wr_en` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_capture | input | 1 | Header strobe; stores the destination code |
| dest_in | input | 2 | Destination code taken from the input byte |
| wr_req | input | 1 | Write strobe from the controller |
| full_in | input | 3 | Full flag of each output queue |
| empty_in | input | 3 | Empty flag of each output queue |
| sel_full | output | 1 | Full flag of the selected queue |
| sel_empty | output | 1 | Empty flag of the selected queue |
| wr_en | output | 3 | Write enable for each output queue |
| port_valid | output | 3 | Data available on each output port |

## Verification
The bench sets up flag patterns in which the selected queue's flags differ from those of the other queues. A selector wired to the wrong index would therefore return a visibly wrong pair. Code 3 is driven with every queue empty and with every queue full: a design that fails to force the blocking pair would let the controller start a load toward no queue. A design that writes anyway would show a stray bit on `wr_en`. Further tests change `dest_in` between headers to catch a selector that reads the live input instead of the stored code, and change the flags with no clock edge to catch a registered path. Finally, the bench raises `wr_req` during reset to catch an enable that is not gated.

// File: rtl/chan_steer.sv
module chan_steer #(
  parameter int PORTS = 3,
  parameter int AW    = $clog2(PORTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_capture,
  input  logic [AW-1:0]    dest_in,
  input  logic             wr_req,
  input  logic [PORTS-1:0] full_in,
  input  logic [PORTS-1:0] empty_in,
  output logic             sel_full,
  output logic             sel_empty,
  output logic [PORTS-1:0] wr_en,
  output logic [PORTS-1:0] port_valid
);

  localparam logic [AW:0] PORTS_W = PORTS[AW:0];

  logic [AW-1:0] addr_q;
  logic          addr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)            addr_q <= '0;
    else if (addr_capture) addr_q <= dest_in;
  end

  assign addr_ok    = {1'b0, addr_q} < PORTS_W;
  assign sel_full   = addr_ok ? full_in[addr_q]  : 1'b1;
  assign sel_empty  = addr_ok ? empty_in[addr_q] : 1'b0;
  assign port_valid = ~empty_in;

  for (genvar g = 0; g < PORTS; g++) begin : g_wr
    assign wr_en[g] = rst_n & wr_req & addr_ok & (addr_q == AW'(g));
  end

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_capture |=> addr_q == $past(dest_in)); // R1

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_capture |=> $stable(addr_q)); // R1

  AST_BAD_CODE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok |-> (sel_full && !sel_empty && wr_en == '0)); // R3

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && addr_ok) |-> $countones(wr_en) == 1); // R5

  AST_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |-> wr_en == '0); // R6

  AST_WR_ONEHOT0: assert property (@(posedge clk) $onehot0(wr_en)); // R5

endmodule

// File: tb/tb_chan_steer.sv
`timescale 1ns/1ps
module tb_chan_steer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       addr_capture = 0;
  logic [1:0] dest_in = 0;
  logic       wr_req = 0;
  logic [2:0] full_in = 0;
  logic [2:0] empty_in = 3'b111;
  logic       sel_full, sel_empty;
  logic [2:0] wr_en, port_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  chan_steer dut (
    .clk(clk), .rst_n(rst_n), .addr_capture(addr_capture), .dest_in(dest_in),
    .wr_req(wr_req), .full_in(full_in), .empty_in(empty_in),
    .sel_full(sel_full), .sel_empty(sel_empty), .wr_en(wr_en), .port_valid(port_valid)
  );

  always #4 clk = ~clk;

  // {code, wr_req, full, empty, exp_full, exp_empty, exp_wr, exp_valid}
  localparam logic [16:0] VEC [8] = '{
    {2'd0, 1'b1, 3'b001, 3'b110, 1'b1, 1'b0, 3'b001, 3'b001},
    {2'd0, 1'b1, 3'b110, 3'b001, 1'b0, 1'b1, 3'b001, 3'b110},
    {2'd1, 1'b1, 3'b010, 3'b000, 1'b1, 1'b0, 3'b010, 3'b111},
    {2'd1, 1'b0, 3'b101, 3'b010, 1'b0, 1'b1, 3'b000, 3'b101},
    {2'd2, 1'b1, 3'b011, 3'b011, 1'b0, 1'b0, 3'b100, 3'b100},
    {2'd2, 1'b1, 3'b100, 3'b100, 1'b1, 1'b1, 3'b100, 3'b011},
    {2'd3, 1'b1, 3'b000, 3'b111, 1'b1, 1'b0, 3'b000, 3'b000},
    {2'd3, 1'b0, 3'b111, 3'b000, 1'b1, 1'b0, 3'b000, 3'b111}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic capture(input logic [1:0] code);
    @(negedge clk);
    dest_in = code; addr_capture = 1; wr_req = 0;
    @(negedge clk);
    addr_capture = 0; dest_in = ~code;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wr_req = 1;
    repeat (2) @(negedge clk);
    check("R7 reset wr_en", {5'd0, wr_en}, 8'h00);
    check("R7 reset code 0 full", {7'd0, sel_full}, 8'h00);
    full_in = 3'b001; #1;
    check("R7 reset code 0 selects port 0", {7'd0, sel_full}, 8'h01);
    full_in = 3'b000; wr_req = 0;
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 8; i++) begin
      logic [16:0] v;
      string rf;
      string rw;
      v = VEC[i];
      rf = (v[16:15] == 2'd3) ? "R3 flags" : "R2 flags";
      rw = (v[14] && v[16:15] != 2'd3) ? "R5 wr_en" : "R6 wr_en";
      capture(v[16:15]);
      wr_req = v[14]; full_in = v[13:11]; empty_in = v[10:8];
      #1;
      check(rf, {6'd0, sel_full, sel_empty}, {6'd0, v[7:6]});
      check(rw, {5'd0, wr_en}, {5'd0, v[5:3]});
      check("R4 port_valid", {5'd0, port_valid}, {5'd0, v[2:0]});
    end

    capture(2'd1);
    full_in = 3'b010; empty_in = 3'b101; wr_req = 1;
    dest_in = 2'd2;
    repeat (3) @(negedge clk);
    dest_in = 2'd3;
    @(negedge clk);
    check("R1 hold flags", {6'd0, sel_full, sel_empty}, 8'h02);
    check("R1 hold wr_en", {5'd0, wr_en}, 8'h02);

    full_in = 3'b000; empty_in = 3'b111; #1;
    check("R8 same-cycle flags", {6'd0, sel_full, sel_empty}, 8'h01);
    wr_req = 0; #1;
    check("R8 same-cycle wr_en", {5'd0, wr_en}, 8'h00);

    capture(2'd2);
    wr_req = 1; #1;
    check("R1 new header wr_en", {5'd0, wr_en}, 8'h04);
    @(negedge clk);
    rst_n = 0; dest_in = 2'd1; addr_capture = 1; #1;
    check("R7 reset gates wr_en", {5'd0, wr_en}, 8'h00);
    @(negedge clk);
    rst_n = 1; addr_capture = 0; #1;
    check("R7 code cleared to 0", {5'd0, wr_en}, 8'h01);

    finish_run();
  end
endmodule